// File: doc/BRIEF.md
# E1 CRC-4 Regenerator and Inserter

This block sits inline on a serial E1 bit stream and rewrites the four CRC-4 check bits that ride in timeslot 0. It is fed one bit per clock, together with a frame marker and a multiframe marker from an upstream aligner. Every bit comes out one clock later. Only the check-bit positions can differ from the input.

A two-bit mode input selects the policy for those positions. In calculate mode the block divides each 2048-bit sub-multiframe by x^4 + x + 1 and places the remainder in the next sub-multiframe. In program mode it places a host-supplied 4-bit pattern instead, and repeats it in every sub-multiframe. In pass mode the check bits leave untouched. The mode and the pattern are captured only at sub-multiframe starts, so the four check bits of one sub-multiframe never come from two different policies.

Top module: `crc4_regen`

## Requirements
- R1: Every bit that is not a check-bit position appears on `ser_out` exactly one clock after it was presented on `ser_in`, unchanged.
- R2: `frame_mark` flags bit 0 of a 256-bit frame. `mfrm_mark` flags bit 0 of frame 0 of a 16-frame multiframe. The check-bit positions are bit 0 of frames 0, 2, 4 and 6 of each 8-frame half, and they carry C1, C2, C3 and C4 in that order.
- R3: In calculate mode (`mode_sel` = 01), C1..C4 carry the remainder of the previous sub-multiframe's 2048 bits, with its own check positions taken as 0, multiplied by x^4 and divided by x^4 + x + 1. C1 is the x^3 coefficient.
- R4: In calculate mode, the check bits of the first sub-multiframe after the first `mfrm_mark` pass unchanged, because no complete sub-multiframe precedes them.
- R5: In program mode (`mode_sel` = 10), C1..C4 are replaced by `prog_pat[3]`, `prog_pat[2]`, `prog_pat[1]` and `prog_pat[0]`. This repeats in every sub-multiframe while the mode stays the same.
- R6: In pass mode (`mode_sel` = 00), and for the reserved code 11, the check bits pass unchanged.
- R7: `mode_sel` and `prog_pat` are sampled only on the first bit of each sub-multiframe (bit 0 of frame 0 or frame 8). A change that arrives in the middle of a sub-multiframe takes effect at the next one.
- R8: Until the first `mfrm_mark` has been seen, every bit passes unchanged, whatever the mode.
- R9: While `rst_n` is low, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Incoming serial E1 bit |
| frame_mark | input | 1 | High on bit 0 of each frame |
| mfrm_mark | input | 1 | High on bit 0 of frame 0 of each multiframe |
| mode_sel | input | 2 | Check-bit policy: 00 pass, 01 calculate, 10 program, 11 pass |
| prog_pat | input | 4 | Host pattern for C1..C4, most significant bit to C1 |
| ser_out | output | 1 | Outgoing serial bit, one clock behind `ser_in` |

## Verification
The hardest cases to reach are the boundary effects. A mode or pattern write that lands in the middle of a sub-multiframe must not touch that sub-multiframe. The first sub-multiframe after lock has no valid remainder to insert.

The bench selects calculate mode before any multiframe marker arrives, so lock happens with that mode already active. It then changes the mode and the pattern at chosen offsets inside a sub-multiframe. A bench-side model samples the controls only on sub-multiframe starts and forms each expected remainder by polynomial long division over the bits it drove. It compares all outputs bit for bit, across random, all-ones and random-with-pass stretches.

// File: rtl/e1c4_pkg.sv
package e1c4_pkg;
   typedef enum logic [1:0] {
      CM_PASS = 2'b00,
      CM_CALC = 2'b01,
      CM_PROG = 2'b10,
      CM_RSVD = 2'b11
   } crc_mode_e;
endpackage

// File: rtl/e1c4_pos.sv
// Tracks the bit and frame position and flags check-bit slots.
module e1c4_pos #(
   parameter int FRAME_BITS = 256,
   parameter int SMF_FRAMES = 8,
   parameter int SMF_COUNT  = 2,
   localparam int BIT_W     = $clog2(FRAME_BITS),
   localparam int FRM_W     = $clog2(SMF_FRAMES * SMF_COUNT),
   localparam int SMF_W     = $clog2(SMF_FRAMES),
   localparam int SLOT_W    = SMF_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_mark,
   input  logic              mfrm_mark,
   output logic              lock_now,
   output logic              was_locked,
   output logic              smf_bnd,
   output logic              cpos,
   output logic [SLOT_W-1:0] slot
);
   logic [BIT_W-1:0] bit_q, bit_c;
   logic [FRM_W-1:0] frm_q, frm_c;
   logic             locked_q;

   always_comb begin
      bit_c = frame_mark ? '0 : bit_q;
      if (mfrm_mark)       frm_c = '0;
      else if (frame_mark) frm_c = frm_q + 1'b1;
      else                 frm_c = frm_q;
   end

   assign lock_now   = locked_q | mfrm_mark;
   assign was_locked = locked_q;
   assign smf_bnd    = lock_now && (bit_c == '0) && (frm_c[SMF_W-1:0] == '0);
   assign cpos       = lock_now && (bit_c == '0) && !frm_c[0];
   assign slot       = frm_c[SMF_W-1:1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q    <= '0;
         frm_q    <= '0;
         locked_q <= 1'b0;
      end else begin
         bit_q    <= bit_c + 1'b1;
         frm_q    <= frm_c;
         locked_q <= lock_now;
      end
   end
endmodule

// File: rtl/e1c4_crc.sv
// Serial remainder engine, restarted at each sub-multiframe boundary.
module e1c4_crc #(
   parameter int               CRC_W = 4,
   parameter logic [CRC_W-1:0] POLY  = 4'h3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_d,
   input  logic             smf_bnd,
   output logic [CRC_W-1:0] crc_now,
   output logic [CRC_W-1:0] crc_hold
);
   logic [CRC_W-1:0] run_q, cur, nxt;
   logic             fb;

   assign cur = smf_bnd ? '0 : run_q;
   assign fb  = cur[CRC_W-1] ^ bit_d;

   for (genvar i = 0; i < CRC_W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign nxt[i] = POLY[i] & fb;
      end else begin : g_up
         assign nxt[i] = cur[i-1] ^ (POLY[i] & fb);
      end
   end

   assign crc_now = smf_bnd ? run_q : crc_hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= '0;
         crc_hold <= '0;
      end else begin
         run_q <= nxt;
         if (smf_bnd) crc_hold <= run_q;
      end
   end
endmodule

// File: rtl/e1c4_insert.sv
// Latches the policy per sub-multiframe and drives the registered output.
module e1c4_insert
   import e1c4_pkg::*;
#(
   parameter int CRC_W  = 4,
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_in,
   input  logic              smf_bnd,
   input  logic              cpos,
   input  logic [SLOT_W-1:0] slot,
   input  logic              was_locked,
   input  logic [1:0]        mode_sel,
   input  logic [CRC_W-1:0]  prog_pat,
   input  logic [CRC_W-1:0]  crc_now,
   output crc_mode_e         mode_act,
   output logic              ser_out
);
   crc_mode_e         mode_eff;
   logic [CRC_W-1:0]  pat_q, pat_eff;
   logic              hv_q, hv_eff, pick;
   logic [SLOT_W-1:0] rev;

   assign mode_eff = smf_bnd ? crc_mode_e'(mode_sel) : mode_act;
   assign pat_eff  = smf_bnd ? prog_pat : pat_q;
   assign hv_eff   = smf_bnd ? was_locked : hv_q;
   assign rev      = SLOT_W'(CRC_W - 1) - slot;

   always_comb begin
      unique case (mode_eff)
         CM_CALC: pick = hv_eff ? crc_now[rev] : ser_in;
         CM_PROG: pick = pat_eff[rev];
         default: pick = ser_in;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_act <= CM_PASS;
         pat_q    <= '0;
         hv_q     <= 1'b0;
         ser_out  <= 1'b0;
      end else begin
         if (smf_bnd) begin
            mode_act <= crc_mode_e'(mode_sel);
            pat_q    <= prog_pat;
            hv_q     <= was_locked;
         end
         ser_out <= cpos ? pick : ser_in;
      end
   end
endmodule

// File: rtl/crc4_regen.sv
module crc4_regen
   import e1c4_pkg::*;
#(
   parameter int               FRAME_BITS = 256,
   parameter int               SMF_FRAMES = 8,
   parameter int               SMF_COUNT  = 2,
   parameter int               CRC_W      = 4,
   parameter logic [CRC_W-1:0] POLY       = 4'h3,
   localparam int              SMF_W      = $clog2(SMF_FRAMES),
   localparam int              SLOT_W     = SMF_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_in,
   input  logic             frame_mark,
   input  logic             mfrm_mark,
   input  logic [1:0]       mode_sel,
   input  logic [CRC_W-1:0] prog_pat,
   output logic             ser_out
);
   if ((1 << $clog2(FRAME_BITS)) != FRAME_BITS) begin : g_bad_frame
      $error("FRAME_BITS must be a power of two");
   end
   if ((1 << SMF_W) != SMF_FRAMES || SMF_FRAMES != 2 * CRC_W) begin : g_bad_smf
      $error("SMF_FRAMES must be a power of two equal to 2*CRC_W");
   end
   if ((1 << $clog2(SMF_COUNT)) != SMF_COUNT) begin : g_bad_cnt
      $error("SMF_COUNT must be a power of two");
   end

   logic              lock_now, was_locked, smf_bnd, cpos;
   logic [SLOT_W-1:0] slot;
   logic [CRC_W-1:0]  crc_now, crc_hold;
   crc_mode_e         mode_act;

   e1c4_pos #(.FRAME_BITS(FRAME_BITS), .SMF_FRAMES(SMF_FRAMES), .SMF_COUNT(SMF_COUNT)) pos_i (
      .clk(clk), .rst_n(rst_n), .frame_mark(frame_mark), .mfrm_mark(mfrm_mark),
      .lock_now(lock_now), .was_locked(was_locked), .smf_bnd(smf_bnd),
      .cpos(cpos), .slot(slot)
   );

   e1c4_crc #(.CRC_W(CRC_W), .POLY(POLY)) crc_i (
      .clk(clk), .rst_n(rst_n), .bit_d(cpos ? 1'b0 : ser_in), .smf_bnd(smf_bnd),
      .crc_now(crc_now), .crc_hold(crc_hold)
   );

   e1c4_insert #(.CRC_W(CRC_W), .SLOT_W(SLOT_W)) ins_i (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .smf_bnd(smf_bnd), .cpos(cpos),
      .slot(slot), .was_locked(was_locked), .mode_sel(mode_sel), .prog_pat(prog_pat),
      .crc_now(crc_now), .mode_act(mode_act), .ser_out(ser_out)
   );
endmodule

// File: rtl/e1c4_chk.sv
module e1c4_chk
   import e1c4_pkg::*;
#(
   parameter int CRC_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ser_in,
   input logic             ser_out,
   input logic             cpos,
   input logic             smf_bnd,
   input logic             lock_now,
   input crc_mode_e        mode_act,
   input logic [CRC_W-1:0] crc_hold
);
   // R1
   payload_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpos |=> ser_out == $past(ser_in));

   // R8
   prelock_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_now |=> ser_out == $past(ser_in));

   // R7
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smf_bnd |=> mode_act == $past(mode_act));

   // R3
   remainder_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smf_bnd |=> $stable(crc_hold));

   // R6
   pass_cbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpos && !smf_bnd && (mode_act == CM_PASS || mode_act == CM_RSVD)) |=> ser_out == $past(ser_in));

   // R2
   single_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smf_bnd |=> !smf_bnd);
endmodule

bind crc4_regen e1c4_chk #(.CRC_W(CRC_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(ser_out), .cpos(cpos),
   .smf_bnd(smf_bnd), .lock_now(lock_now), .mode_act(mode_act), .crc_hold(crc_hold)
);

// File: tb/crc4_regen_tb_top.sv
`timescale 1ns/1ps
module crc4_regen_tb_top;
   logic       clk = 1'b0, rst_n = 1'b0, ser_in = 1'b0;
   logic       frame_mark = 1'b0, mfrm_mark = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic [3:0] prog_pat = 4'h0;
   logic       ser_out;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [1:0] nx_mode = 2'b00;
   logic [3:0] nx_pat  = 4'h0;
   bit         aligned = 0;
   int         n = 0;
   bit         m_locked = 0, m_hv = 0;
   logic [1:0] m_mode = 2'b00;
   logic [3:0] m_pat = 4'h0, m_crc = 4'h0;
   bit         sbuf [2048];
   bit         have_prev = 0;
   logic       exp_prev = 1'b0;
   string      tag_prev = "";
   logic [15:0] lf = 16'hACE1;

   always #2 clk = ~clk;

   crc4_regen dut_i (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_mark(frame_mark),
      .mfrm_mark(mfrm_mark), .mode_sel(mode_sel), .prog_pat(prog_pat), .ser_out(ser_out)
   );

   task automatic check(logic act, logic exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at n=%0d: got %b expected %b", tag, n, act, exp);
      end
   endtask

   // Long division of the stored sub-multiframe (times x^4) by 1 0011.
   function automatic logic [3:0] div_rem();
      bit a [2052];
      for (int i = 0; i < 2048; i++) a[i] = sbuf[i];
      for (int i = 2048; i < 2052; i++) a[i] = 1'b0;
      for (int i = 0; i < 2048; i++) begin
         if (a[i]) begin
            a[i]   = 1'b0;
            a[i+3] = ~a[i+3];
            a[i+4] = ~a[i+4];
         end
      end
      return {a[2048], a[2049], a[2050], a[2051]};
   endfunction

   task automatic step(bit d);
      int   b, f, fs, slot;
      bit   cp;
      logic e;
      string t;
      @(negedge clk);
      if (have_prev) check(ser_out, exp_prev, tag_prev);
      mode_sel = nx_mode;
      prog_pat = nx_pat;
      ser_in   = d;
      if (aligned) begin
         b  = n % 256;
         f  = (n / 256) % 16;
         fs = f % 8;
         frame_mark = (b == 0);
         mfrm_mark  = (b == 0) && (f == 0);
         if (n % 2048 == 0) begin  // R7: controls captured only here
            m_crc    = div_rem();
            m_hv     = m_locked;
            m_locked = 1;
            m_mode   = mode_sel;
            m_pat    = prog_pat;
         end
         cp   = (b == 0) && (fs % 2 == 0);  // R2 slot positions
         slot = fs / 2;
         sbuf[n % 2048] = cp ? 1'b0 : d;
         if (!cp) begin
            e = d; t = "R1 payload bit";
         end else if (m_mode == 2'b01 && m_hv) begin
            e = m_crc[3 - slot]; t = "R3 computed C bit (R2 slot)";
         end else if (m_mode == 2'b01) begin
            e = d; t = "R4 first sub-multiframe C bit";
         end else if (m_mode == 2'b10) begin
            e = m_pat[3 - slot]; t = "R5 programmed C bit (R7 sampling)";
         end else begin
            e = d; t = "R6 pass-mode C bit";
         end
         n++;
      end else begin
         frame_mark = 1'b0;
         mfrm_mark  = 1'b0;
         e = d; t = "R8 pre-lock bit";
      end
      exp_prev  = e;
      tag_prev  = t;
      have_prev = 1;
   endtask

   function automatic bit gen(int kind);
      if (kind == 1) return 1'b1;
      if (kind == 2) return 1'b0;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      return lf[0];
   endfunction

   task automatic run(int cnt, int kind);
      for (int i = 0; i < cnt; i++) step(gen(kind));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(ser_out, 1'b0, "R9 reset output");
      ser_in = 1'b1;
      @(negedge clk);
      check(ser_out, 1'b0, "R9 reset output with input high");
      rst_n = 1'b1;
      // R8: calculate mode chosen before any multiframe marker
      nx_mode = 2'b01;
      run(300, 0);
      aligned = 1;
      // R4 then R3: first sub-multiframe unchanged, later ones computed
      run(4096, 0);
      run(4096, 1);
      run(4096, 0);
      // R7: mid-sub-multiframe switch to program mode
      run(1000, 0);
      nx_mode = 2'b10;
      nx_pat  = 4'hA;
      run(3000, 0);
      nx_pat  = 4'h5;
      run(2000, 0);
      // R6: reserved code, then pass
      nx_mode = 2'b11;
      run(2048, 1);
      nx_mode = 2'b00;
      run(4096, 0);
      // R3 again after pass, all-ones payload
      nx_mode = 2'b01;
      run(4096, 1);
      step(1'b0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule